// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Sticky Error Flags

This block moves one byte at a time over a four-wire serial link. It acts as the clocking side (master) or the clocked side (slave). Software reaches it through three small registers: a control/status register, a data register and an interrupt-enable register. A single-entry transmit holding register feeds the shift register. A single-entry receive holding register keeps the last completed byte until software reads it.

Four sticky flags report what happened on the link: byte finished, data write refused, bus contention detected, and received byte lost. They are combined into one interrupt line. As master, the block makes the serial clock from the system clock with a fixed divider. The clock idles low, the input is sampled on the rising edge and the output changes on the falling edge. As slave, it resynchronises the external clock, data and select inputs and samples the data on rising clock edges while select is low.

Top module: `spi_flag_port`

## Requirements
- R1: After reset the control register (address 0), data register (address 1) and interrupt-enable register (address 2) read 0 and `irq` is low.
- R2: With enable (control bit 0) and master (control bit 2) set, a byte written to the data register is sent MSB first on `mosi_o`. The transfer uses exactly 8 rising edges of `sclk_o`, which idles low. `miso_i` is sampled on each rising edge, and the assembled byte becomes readable at the data register.
- R3: The transfer-complete flag (control bit 7) sets at the end of every byte, in master and in slave mode.
- R4: A data-register write while the transmit holding register is still full sets the write-collision flag (control bit 6). That write is discarded and the held byte is sent unchanged.
- R5: With enable, master and multi-master (control bit 3) set, a low level on `nss_i` sets the mode-fault flag (control bit 5) and clears the master and enable bits.
- R6: In slave mode, a byte that completes while the receive holding register is unread sets the overrun flag (control bit 4). The new byte is dropped and the older one stays readable.
- R7: Hardware never clears a flag. A control write with a 0 in a flag bit clears that flag, and a 1 leaves it as it was.
- R8: `irq` is high exactly when the interrupt-enable bit (bit 0 at address 2) is 1 and at least one of the four flags is 1.
- R9: In slave mode the block shifts `mosi_i` in on synchronised rising edges of `sclk_i` while `nss_i` is low. A byte written while `nss_i` is high appears MSB first on `miso_o`.
- R10: Reading the data register returns the received byte and empties the receive holding register, so the next slave byte is stored without an overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on the data register) |
| addr | input | 2 | Register select: 0 control, 1 data, 2 interrupt enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Combined flag interrupt |
| sclk_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out, master mode |
| miso_i | input | 1 | Serial data in, master mode |
| sclk_i | input | 1 | External serial clock, slave mode |
| mosi_i | input | 1 | Serial data in, slave mode |
| miso_o | output | 1 | Serial data out, slave mode |
| nss_i | input | 1 | Active-low select / contention sense |

## Verification
The in-RTL properties check on every cycle that the master clock stays low while no byte is in flight and that a completed master byte follows a busy period. They also check that a mode fault leaves the master and enable bits cleared, that a refused write leaves the held byte untouched, and that an overrun leaves the stored byte unchanged. Only the bench scenarios can show bit order, the exact number of clock edges, the byte values that reach the data register after a collision or an overrun, the clear-by-zero flag rule, and the interrupt following the enable bit.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_IEN  = 2'd2
    } reg_sel_e;

    // control register bit positions
    localparam int B_DONE  = 7;
    localparam int B_WCOL  = 6;
    localparam int B_MODF  = 5;
    localparam int B_OVR   = 4;
    localparam int B_MULTI = 3;
    localparam int B_MST   = 2;
    localparam int B_EN    = 0;

    typedef struct packed {
        logic done;
        logic wcol;
        logic modf;
        logic ovr;
    } flags_t;

    // hardware set wins over a software clear in the same cycle
    function automatic flags_t flag_next(flags_t cur, flags_t hw_set,
                                         logic sw_wr, logic [3:0] sw_keep);
        logic [3:0] keep;
        keep = sw_wr ? sw_keep : 4'hF;
        return flags_t'(hw_set | (cur & keep));
    endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= RST_VAL;
                else if (g == 0) stage[g] <= d;
                else stage[g] <= stage[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_flag_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  master,
    input  logic  load,
    input  byte_t load_data,
    input  logic  miso_i,
    input  logic  sclk_s,
    input  logic  mosi_s,
    input  logic  nss_s,
    output logic  sclk_o,
    output logic  mosi_o,
    output logic  miso_o,
    output logic  ready,
    output logic  byte_done,
    output byte_t rx_byte
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    byte_t            shreg;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] div;
    logic             sclk_q, busy, samp, done_q, sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0; cnt <= '0; div <= '0;
            sclk_q <= 1'b0; busy <= 1'b0; samp <= 1'b0;
            done_q <= 1'b0; sclk_prev <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            sclk_prev <= sclk_s;
            if (!active) begin
                busy <= 1'b0; sclk_q <= 1'b0; cnt <= '0; div <= '0;
            end else if (master) begin
                if (load) begin
                    shreg <= load_data; busy <= 1'b1;
                    sclk_q <= 1'b0; cnt <= '0; div <= '0;
                end else if (busy) begin
                    if (div == DIV_LAST) begin
                        div    <= '0;
                        sclk_q <= ~sclk_q;
                        if (!sclk_q) begin
                            samp <= miso_i;
                        end else begin
                            shreg <= {shreg[DATA_W-2:0], samp};
                            cnt   <= cnt + 1'b1;
                            if (cnt == CNT_LAST) begin
                                busy <= 1'b0; done_q <= 1'b1; cnt <= '0;
                            end
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
            end else begin
                busy <= 1'b0; sclk_q <= 1'b0;
                if (nss_s) begin
                    cnt <= '0;
                    if (load) shreg <= load_data;
                end else if (sclk_s && !sclk_prev) begin
                    shreg <= {shreg[DATA_W-2:0], mosi_s};
                    cnt   <= cnt + 1'b1;
                    if (cnt == CNT_LAST) begin
                        done_q <= 1'b1; cnt <= '0;
                    end
                end
            end
        end
    end

    assign sclk_o    = sclk_q;
    assign mosi_o    = shreg[DATA_W-1];
    assign miso_o    = shreg[DATA_W-1];
    assign ready     = master ? !busy : nss_s;
    assign byte_done = done_q;
    assign rx_byte   = shreg;

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk_q);

    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && master && $past(master)) |-> $past(busy));
endmodule

// File: rtl/spi_flag_port.sv
module spi_flag_port
    import spi_flag_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       sclk_o,
    output logic       mosi_o,
    input  logic       miso_i,
    input  logic       sclk_i,
    input  logic       mosi_i,
    output logic       miso_o,
    input  logic       nss_i
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    flags_t flg;
    logic   multi, mst, en, ien;
    byte_t  txbuf, rxbuf;
    logic   txfull, rxfull;

    logic [2:0] sync_q;
    logic       sclk_s, mosi_s, nss_s;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst), .d({nss_i, mosi_i, sclk_i}), .q(sync_q));
    assign {nss_s, mosi_s, sclk_s} = sync_q;

    logic  load, ready, byte_done;
    byte_t rx_byte;

    assign load = en && txfull && ready;

    spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst(rst), .active(en), .master(mst),
        .load(load), .load_data(txbuf), .miso_i(miso_i),
        .sclk_s(sclk_s), .mosi_s(mosi_s), .nss_s(nss_s),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_o(miso_o),
        .ready(ready), .byte_done(byte_done), .rx_byte(rx_byte));

    logic   wr_ctrl, wr_data, wr_ien, rd_data;
    logic   modf_evt, ovr_evt;
    flags_t hw_set;

    assign wr_ctrl  = wr_en && (sel == REG_CTRL);
    assign wr_data  = wr_en && (sel == REG_DATA);
    assign wr_ien   = wr_en && (sel == REG_IEN);
    assign rd_data  = rd_en && (sel == REG_DATA);
    assign modf_evt = en && mst && multi && !nss_s;
    assign ovr_evt  = byte_done && !mst && rxfull && !rd_data;
    assign hw_set   = '{done: byte_done, wcol: wr_data && txfull,
                        modf: modf_evt, ovr: ovr_evt};

    always_ff @(posedge clk) begin
        if (rst) begin
            flg <= '0; multi <= 1'b0; mst <= 1'b0; en <= 1'b0; ien <= 1'b0;
            txbuf <= '0; rxbuf <= '0; txfull <= 1'b0; rxfull <= 1'b0;
        end else begin
            flg <= flag_next(flg, hw_set, wr_ctrl, wdata[B_DONE:B_OVR]);
            if (wr_ctrl) begin
                multi <= wdata[B_MULTI];
                mst   <= wdata[B_MST];
                en    <= wdata[B_EN];
            end
            if (modf_evt) begin
                mst <= 1'b0;
                en  <= 1'b0;
            end
            if (wr_ien) ien <= wdata[0];
            if (wr_data && !txfull) begin
                txbuf  <= wdata;
                txfull <= 1'b1;
            end else if (load) begin
                txfull <= 1'b0;
            end
            if (rd_data) rxfull <= 1'b0;
            if (byte_done && !ovr_evt) begin
                rxbuf  <= rx_byte;
                rxfull <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            REG_CTRL: begin
                rdata[B_DONE:B_OVR] = flg;
                rdata[B_MULTI]      = multi;
                rdata[B_MST]        = mst;
                rdata[B_EN]         = en;
            end
            REG_DATA: rdata = rxbuf;
            REG_IEN:  rdata[0] = ien;
            default:  rdata = '0;
        endcase
    end

    assign irq = ien && (|flg);

    // R5
    modf_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flg.modf) |-> (!mst && !en));

    // R4
    wcol_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data && txfull) |=> (txbuf == $past(txbuf)));

    // R6
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> $stable(rxbuf));
endmodule

// File: tb/sim_spi_flag_port.sv
module sim_spi_flag_port;
    localparam int PER = 10;

    logic       clk = 1'b0, rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00, rdata;
    logic       irq, sclk_o, mosi_o, miso_o;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, nss_i = 1'b1;
    logic       loop_en = 1'b1;
    logic       miso_i;

    assign miso_i = loop_en ? mosi_o : 1'b0;

    spi_flag_port u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .sclk_i(sclk_i), .mosi_i(mosi_i),
        .miso_o(miso_o), .nss_i(nss_i));

    always #(PER/2) clk = ~clk;

    int   n_vec = 0, n_bad = 0;
    logic done_run = 1'b0;

    // scoreboard queues filled by the driver, drained by the monitor
    string      q_req[$];
    logic [7:0] q_exp[$];
    event       mon_ev;

    initial begin
        forever begin
            @(mon_ev);
            if (q_exp.size() > 0) begin
                string      r;
                logic [7:0] e;
                r = q_req.pop_front();
                e = q_exp.pop_front();
                n_vec++;
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", r, rdata, e);
                end
            end
        end
    end

    // master-side bus observation
    int         sclk_rises = 0;
    logic [7:0] mosi_cap = 8'h00;
    always @(posedge sclk_o) begin
        sclk_rises++;
        mosi_cap = {mosi_cap[6:0], mosi_o};
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_expect(input string req, input logic [1:0] a, input logic [7:0] e);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        q_req.push_back(req);
        q_exp.push_back(e);
        #(PER/4);
        -> mon_ev;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bit-banged external master talking to the block in slave mode
    task automatic ext_byte(input logic [7:0] d, output logic [7:0] got);
        got = 8'h00;
        nss_i = 1'b0;
        idle(6);
        for (int i = 7; i >= 0; i--) begin
            mosi_i = d[i];
            idle(6);
            got = {got[6:0], miso_o};
            sclk_i = 1'b1;
            idle(6);
            sclk_i = 1'b0;
        end
        idle(6);
        nss_i = 1'b1;
        idle(6);
    endtask

    initial begin
        #(PER * 150000);
        if (!done_run) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        idle(3);
        @(negedge clk) rst = 1'b0;
        idle(2);

        // R1 reset state
        reg_expect("R1 ctrl", 2'd0, 8'h00);
        reg_expect("R1 data", 2'd1, 8'h00);
        reg_expect("R1 ien", 2'd2, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // R2/R3 master single byte, loopback of mosi to miso
        reg_wr(2'd0, 8'h05);
        sclk_rises = 0;
        reg_wr(2'd1, 8'hA5);
        idle(90);
        chk("R2 sclk rising edges", 8'(sclk_rises), 8'd8);
        chk("R2 msb-first on mosi", mosi_cap, 8'hA5);
        chk("R2 sclk idles low", {7'b0, sclk_o}, 8'h00);
        reg_expect("R3 done flag master", 2'd0, 8'h85);
        reg_expect("R2 received byte", 2'd1, 8'hA5);

        // R4 write collision: second byte held, third dropped
        reg_wr(2'd0, 8'h05);
        sclk_rises = 0;
        reg_wr(2'd1, 8'h3E);
        reg_wr(2'd1, 8'hC7);
        @(negedge clk);
        addr = 2'd1; wdata = 8'h11; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        idle(180);
        chk("R4 only two bytes sent", 8'(sclk_rises), 8'd16);
        chk("R4 held byte sent intact", mosi_cap, 8'hC7);
        reg_expect("R4 wcol flag", 2'd0, 8'hC5);
        reg_expect("R4 dropped write not received", 2'd1, 8'hC7);

        // R5 mode fault
        reg_wr(2'd0, 8'h0D);
        nss_i = 1'b0;
        idle(6);
        reg_expect("R5 modf set, mst/en cleared", 2'd0, 8'h28);

        // R8 interrupt follows enable and flags
        chk("R8 irq off while disabled", {7'b0, irq}, 8'h00);
        reg_wr(2'd2, 8'h01);
        chk("R8 irq on", {7'b0, irq}, 8'h01);

        // R7 writing ones keeps flags, writing zero clears
        reg_wr(2'd0, 8'hF8);
        reg_expect("R7 ones keep flags", 2'd0, 8'h28);
        nss_i = 1'b1;
        reg_wr(2'd0, 8'h00);
        reg_expect("R7 zero clears flags", 2'd0, 8'h00);
        chk("R8 irq off after clear", {7'b0, irq}, 8'h00);
        reg_wr(2'd2, 8'h00);
        idle(4);

        // R9 slave reception and transmission
        reg_wr(2'd0, 8'h01);
        reg_wr(2'd1, 8'h96);
        idle(4);
        ext_byte(8'h3C, got);
        chk("R9 slave miso byte", got, 8'h96);
        reg_expect("R3 done flag slave", 2'd0, 8'h81);

        // R6 overrun keeps older byte
        ext_byte(8'h81, got);
        reg_expect("R6 ovr flag", 2'd0, 8'h91);
        reg_expect("R6 old byte kept", 2'd1, 8'h3C);

        // R10 read empties the receive register
        reg_wr(2'd0, 8'h01);
        ext_byte(8'h5A, got);
        reg_expect("R10 no overrun after read", 2'd0, 8'h81);
        reg_expect("R10 new byte stored", 2'd1, 8'h5A);

        idle(4);
        done_run = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule